// File: doc/BRIEF.md
# Armed Sync-Triggered Capture Buffer

This block takes a snapshot of a streaming word input into an on-chip buffer so that software can inspect it afterwards through a register port and a buffer read port. Software first programs a skip count and then arms the block by writing a control register. The next sync beat on the stream (a beat with both the sync flag and the valid flag set) opens the capture. The block then drops the first beats given by the skip count, counting only valid beats and starting with the sync beat itself, and writes every later valid beat to consecutive buffer addresses from address 0. Capture ends once the buffer is full. Further input leaves the buffer alone until the block is armed again.

Three status counters sit next to the capture logic. The sync counter counts every sync beat, whether or not the block is armed, and is cleared when software reads the last buffer address. The word counter shows how many words the current capture has written. The valid counter shows how many valid beats have arrived since the latest sync beat. A read-only version word completes the register set.

The register port uses word addresses; the byte offset a host sees is four times the word address. Writing the arm address while a capture is running aborts that capture and waits for a fresh sync beat.

Top module: `sync_capture_buffer`

## Requirements
- R1: After reset the sync counter, the word counter, the valid counter and the skip count (word addresses 0, 1, 2 and 3) all read 0, and no buffer write happens until the block is armed and has seen a sync beat.
- R2: A register write to word address 2 (byte 0x8) arms the block. A sync beat, meaning in_sync=1 together with in_valid=1, starts a capture only while the block is armed. Sync beats seen while not armed leave the word counter unchanged.
- R3: With skip count D (register word address 3, read/write, low SKIP_W bits of the write data), the first D valid beats of a capture are dropped, counting the sync beat as the first of them. The next valid beat is written to buffer address 0. With D=0 the sync beat itself is written to address 0.
- R4: Beats with in_valid=0 neither advance the skip count nor write the buffer. Written beats fill consecutive buffer addresses in arrival order.
- R5: The word counter (word address 1, byte 0x4) reports how many words the current capture has written. It returns to 0 on the sync beat that starts a capture.
- R6: Capture stops after DEPTH words. Later beats, sync beats included, change neither the buffer nor the word counter, which holds DEPTH, until the block is armed again.
- R7: The sync counter (word address 0) increments on every sync beat. A buffer read of address DEPTH-1 clears it. If a sync beat arrives in the same cycle as that read, the counter reads 1 afterwards.
- R8: The valid counter (reads of word address 2) is 0 after each sync beat and increases by one for every following valid beat that is not a sync beat.
- R9: Register reads and buffer reads return data on the clock edge after the request. The version word sits at word address 7 (byte 0x1C) and equals the VERSION parameter. Word addresses 4 to 6 read 0.
- R10: Arming while a capture is waiting out its skip or is filling aborts that capture. No further words are written until a new sync beat arrives.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Stream beat valid |
| in_sync | input | 1 | Stream sync flag, sampled only with in_valid |
| in_data | input | DATA_W | Stream data word |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 3 | Register word address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, one cycle after reg_rd |
| buf_rd | input | 1 | Buffer read strobe |
| buf_addr | input | ADDR_W | Buffer read address |
| buf_rdata | output | DATA_W | Buffer read data, one cycle after buf_rd |

## Verification
The bench builds the block with DEPTH=16 and SKIP_W=8, with DATA_W and VERSION left at their defaults. The small depth puts a full buffer, the stop at full, the clear caused by reading address DEPTH-1 and an abort partway through a fill within a few dozen beats. The 8-bit skip field still covers every skip value the random captures draw, zero included. Random captures mix gaps in in_valid with stray sync beats, so both the skip phase and the fill phase are exercised with idle beats between the valid ones.

// File: rtl/cap_pkg.sv
// Package: shared types and register word addresses of the capture buffer.
// Assumes a 32-bit register port addressed by word.
package cap_pkg;
    localparam int REG_W  = 32;
    localparam int REG_AW = 3;

    localparam logic [REG_AW-1:0] A_SYNC_CNT  = 3'd0;
    localparam logic [REG_AW-1:0] A_WORD_CNT  = 3'd1;
    localparam logic [REG_AW-1:0] A_VALID_ARM = 3'd2;
    localparam logic [REG_AW-1:0] A_SKIP      = 3'd3;
    localparam logic [REG_AW-1:0] A_VERSION   = 3'd7;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ARMED = 2'd1,
        ST_SKIP  = 2'd2,
        ST_FILL  = 2'd3
    } cap_state_t;
endpackage

// File: rtl/cap_ctrl.sv
// Module: capture sequencer. Waits for arm, then a sync beat, skips a
// programmed number of valid beats and issues buffer writes until DEPTH
// words are stored. Assumes sync_ev already includes in_valid.
module cap_ctrl
    import cap_pkg::*;
#(
    parameter int DEPTH  = 1024,
    parameter int SKIP_W = 16,
    localparam int ADDR_W = $clog2(DEPTH),
    localparam int WCNT_W = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              arm,
    input  logic              in_valid,
    input  logic              sync_ev,
    input  logic [SKIP_W-1:0] skip,
    output logic              wr_en,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [WCNT_W-1:0] word_cnt
);
    localparam logic LAST_IS_FIRST = (DEPTH == 1);
    localparam logic [WCNT_W-1:0] LAST_IDX = WCNT_W'(DEPTH - 1);

    cap_state_t        state;
    logic [SKIP_W-1:0] skip_cnt;
    logic              hit_start;
    logic              hit_skip_end;

    // Decode the two ways the first word of a capture is written.
    always_comb begin
        hit_start    = (state == ST_ARMED) && sync_ev && (skip == '0);
        hit_skip_end = (state == ST_SKIP) && in_valid && (skip_cnt == skip);
    end

    // Buffer write strobe and address for the current beat.
    always_comb begin
        wr_en   = !arm && (hit_start || hit_skip_end || ((state == ST_FILL) && in_valid));
        wr_addr = (state == ST_FILL) ? word_cnt[ADDR_W-1:0] : '0;
    end

    // Sequencer state, skip counter and word counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            skip_cnt <= '0;
            word_cnt <= '0;
        end else if (arm) begin
            state    <= ST_ARMED;
        end else begin
            unique case (state)
                ST_ARMED: begin
                    if (sync_ev) begin
                        if (skip == '0) begin
                            word_cnt <= WCNT_W'(1);
                            state    <= LAST_IS_FIRST ? ST_IDLE : ST_FILL;
                        end else begin
                            word_cnt <= '0;
                            skip_cnt <= SKIP_W'(1);
                            state    <= ST_SKIP;
                        end
                    end
                end
                ST_SKIP: begin
                    if (in_valid) begin
                        if (skip_cnt == skip) begin
                            word_cnt <= WCNT_W'(1);
                            state    <= LAST_IS_FIRST ? ST_IDLE : ST_FILL;
                        end else begin
                            skip_cnt <= skip_cnt + SKIP_W'(1);
                        end
                    end
                end
                ST_FILL: begin
                    if (in_valid) begin
                        word_cnt <= word_cnt + WCNT_W'(1);
                        if (word_cnt == LAST_IDX) state <= ST_IDLE;
                    end
                end
                default: ;
            endcase
        end
    end

    // R2: no buffer write while idle.
    p_idle_no_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE) |-> !wr_en);
    // R2: an armed sync beat leaves the armed state.
    p_sync_starts_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_ARMED && sync_ev && !arm) |=> (state != ST_ARMED));
    // R4: writes happen only on valid beats.
    p_write_on_valid_r4: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> in_valid);
    // R6: the word count never passes the buffer depth.
    p_no_overflow_r6: assert property (@(posedge clk) disable iff (!rst_n)
        word_cnt <= WCNT_W'(DEPTH));
    // R6: a full buffer is never in the fill state.
    p_full_stops_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (word_cnt == WCNT_W'(DEPTH)) |-> (state != ST_FILL));
    // R10: arming always returns to the armed state.
    p_rearm_aborts_r10: assert property (@(posedge clk) disable iff (!rst_n)
        arm |=> (state == ST_ARMED));
endmodule

// File: rtl/cap_counters.sv
// Module: sync and valid status counters. Sync count clears on a read of
// the last buffer word; valid count restarts on each sync beat.
// Assumes sync_ev already includes in_valid.
module cap_counters #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic             sync_ev,
    input  logic             last_rd,
    output logic [CNT_W-1:0] sync_cnt,
    output logic [CNT_W-1:0] valid_cnt
);
    // Sync beats counted since the last read of the final buffer word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync_cnt <= '0;
        end else if (last_rd) begin
            sync_cnt <= sync_ev ? CNT_W'(1) : '0;
        end else if (sync_ev) begin
            sync_cnt <= sync_cnt + CNT_W'(1);
        end
    end

    // Valid beats counted since the most recent sync beat.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_cnt <= '0;
        end else if (sync_ev) begin
            valid_cnt <= '0;
        end else if (in_valid) begin
            valid_cnt <= valid_cnt + CNT_W'(1);
        end
    end

    // R7: a read of the last word leaves at most one counted sync.
    p_sync_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
        last_rd |=> (sync_cnt <= CNT_W'(1)));
    // R8: a sync beat restarts the valid count.
    p_valid_restart_r8: assert property (@(posedge clk) disable iff (!rst_n)
        sync_ev |=> (valid_cnt == '0));
    // R8: non-sync valid beats add one.
    p_valid_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !sync_ev) |=> (valid_cnt == $past(valid_cnt) + CNT_W'(1)));
endmodule

// File: rtl/cap_mem.sv
// Module: simple dual-port buffer, one write port and one read port with a
// single cycle of read latency. Contents are not reset.
module cap_mem #(
    parameter int DATA_W = 32,
    parameter int DEPTH  = 1024,
    localparam int ADDR_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data
);
    logic [DATA_W-1:0] store [DEPTH];

    // Storage write.
    always_ff @(posedge clk) begin
        if (wr_en) store[wr_addr] <= wr_data;
    end

    // Registered read.
    always_ff @(posedge clk) begin
        if (!rst_n) rd_data <= '0;
        else if (rd_en) rd_data <= store[rd_addr];
    end
endmodule

// File: rtl/sync_capture_buffer.sv
// Module: top of the armed sync-triggered capture buffer. Holds the skip
// register, decodes arm writes, and muxes status reads. Assumes the
// register port is word addressed and that reads return one cycle later.
module sync_capture_buffer
    import cap_pkg::*;
#(
    parameter int DATA_W  = 32,
    parameter int DEPTH   = 1024,
    parameter int SKIP_W  = 16,
    parameter int CNT_W   = 32,
    parameter logic [31:0] VERSION = 32'h0001_0002,
    localparam int ADDR_W = $clog2(DEPTH),
    localparam int WCNT_W = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic              in_sync,
    input  logic [DATA_W-1:0] in_data,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [2:0]        reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    input  logic              buf_rd,
    input  logic [ADDR_W-1:0] buf_addr,
    output logic [DATA_W-1:0] buf_rdata
);
    logic              sync_ev;
    logic              arm;
    logic              last_rd;
    logic [SKIP_W-1:0] skip;
    logic              wr_en;
    logic [ADDR_W-1:0] wr_addr;
    logic [WCNT_W-1:0] word_cnt;
    logic [CNT_W-1:0]  sync_cnt;
    logic [CNT_W-1:0]  valid_cnt;
    logic              unused_wdata;

    // Qualify strobes: sync beats, arm writes and last-word reads.
    always_comb begin
        sync_ev      = in_sync && in_valid;
        arm          = reg_wr && (reg_addr == A_VALID_ARM);
        last_rd      = buf_rd && (buf_addr == ADDR_W'(DEPTH - 1));
        unused_wdata = ^reg_wdata;
    end

    // Skip count register.
    always_ff @(posedge clk) begin
        if (!rst_n) skip <= '0;
        else if (reg_wr && reg_addr == A_SKIP) skip <= reg_wdata[SKIP_W-1:0];
    end

    // Registered status read mux.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            reg_rdata <= '0;
        end else if (reg_rd) begin
            unique case (reg_addr)
                A_SYNC_CNT:  reg_rdata <= REG_W'(sync_cnt);
                A_WORD_CNT:  reg_rdata <= REG_W'(word_cnt);
                A_VALID_ARM: reg_rdata <= REG_W'(valid_cnt);
                A_SKIP:      reg_rdata <= REG_W'(skip);
                A_VERSION:   reg_rdata <= VERSION;
                default:     reg_rdata <= '0;
            endcase
        end
    end

    cap_ctrl #(.DEPTH(DEPTH), .SKIP_W(SKIP_W)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .arm(arm), .in_valid(in_valid),
        .sync_ev(sync_ev), .skip(skip), .wr_en(wr_en), .wr_addr(wr_addr),
        .word_cnt(word_cnt)
    );

    cap_counters #(.CNT_W(CNT_W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .sync_ev(sync_ev),
        .last_rd(last_rd), .sync_cnt(sync_cnt), .valid_cnt(valid_cnt)
    );

    cap_mem #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_mem (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(in_data), .rd_en(buf_rd), .rd_addr(buf_addr),
        .rd_data(buf_rdata)
    );

    // R9: a version read returns the parameter one cycle later.
    p_version_read_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rd && reg_addr == A_VERSION) |=> (reg_rdata == VERSION));
    // R9: unmapped addresses read zero.
    p_unmapped_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rd && reg_addr > A_SKIP && reg_addr < A_VERSION) |=> (reg_rdata == '0));
    // R9: read data holds when no read is requested.
    p_rdata_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !reg_rd |=> $stable(reg_rdata));
endmodule

// File: tb/sync_capture_buffer_test.sv
module sync_capture_buffer_test;
    localparam int DATA_W = 32;
    localparam int DEPTH  = 16;
    localparam int SKIP_W = 8;
    localparam int ADDR_W = $clog2(DEPTH);
    localparam logic [31:0] VER = 32'h0001_0002;

    localparam int M_IDLE = 0, M_ARMED = 1, M_SKIP = 2, M_FILL = 3;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              in_valid = 1'b0, in_sync = 1'b0;
    logic [DATA_W-1:0] in_data = '0;
    logic              reg_wr = 1'b0, reg_rd = 1'b0;
    logic [2:0]        reg_addr = '0;
    logic [31:0]       reg_wdata = '0;
    logic [31:0]       reg_rdata;
    logic              buf_rd = 1'b0;
    logic [ADDR_W-1:0] buf_addr = '0;
    logic [DATA_W-1:0] buf_rdata;

    int checks = 0, errors = 0;
    bit done = 1'b0;

    // Reference model state
    int          m_st = M_IDLE, m_skipcnt = 0, m_words = 0, m_skip = 0;
    int unsigned m_sync = 0, m_valid = 0;
    logic [DATA_W-1:0] m_mem [DEPTH];

    sync_capture_buffer #(.DATA_W(DATA_W), .DEPTH(DEPTH), .SKIP_W(SKIP_W), .VERSION(VER)) uut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sync(in_sync),
        .in_data(in_data), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .buf_rd(buf_rd),
        .buf_addr(buf_addr), .buf_rdata(buf_rdata)
    );

    always #5 clk = ~clk;

    initial begin
        for (int i = 0; i < 100000; i++) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic void model_beat(bit v, bit s, logic [DATA_W-1:0] d);
        bit sev = v && s;
        if (sev) begin m_sync++; m_valid = 0; end
        else if (v) m_valid++;
        case (m_st)
            M_ARMED: if (sev) begin
                if (m_skip == 0) begin m_mem[0] = d; m_words = 1; m_st = (DEPTH == 1) ? M_IDLE : M_FILL; end
                else begin m_words = 0; m_skipcnt = 1; m_st = M_SKIP; end
            end
            M_SKIP: if (v) begin
                if (m_skipcnt == m_skip) begin m_mem[0] = d; m_words = 1; m_st = M_FILL; end
                else m_skipcnt++;
            end
            M_FILL: if (v) begin
                m_mem[m_words] = d; m_words++;
                if (m_words == DEPTH) m_st = M_IDLE;
            end
            default: ;
        endcase
    endfunction

    task automatic idle_inputs();
        in_valid = 0; in_sync = 0; reg_wr = 0; reg_rd = 0; buf_rd = 0;
    endtask

    task automatic beat(bit v, bit s, logic [DATA_W-1:0] d);
        @(negedge clk);
        idle_inputs();
        in_valid = v; in_sync = s; in_data = d;
        model_beat(v, s, d);
    endtask

    task automatic reg_write(logic [2:0] a, logic [31:0] d);
        @(negedge clk);
        idle_inputs();
        reg_wr = 1; reg_addr = a; reg_wdata = d;
        if (a == 3'd2) m_st = M_ARMED;
        if (a == 3'd3) m_skip = int'(d[SKIP_W-1:0]);
    endtask

    task automatic reg_read(logic [2:0] a, output logic [31:0] d);
        @(negedge clk);
        idle_inputs();
        reg_rd = 1; reg_addr = a;
        @(negedge clk);
        idle_inputs();
        d = reg_rdata;
    endtask

    task automatic buf_read(int a, output logic [DATA_W-1:0] d);
        @(negedge clk);
        idle_inputs();
        buf_rd = 1; buf_addr = ADDR_W'(a);
        if (a == DEPTH - 1) m_sync = 0;
        @(negedge clk);
        idle_inputs();
        d = buf_rdata;
    endtask

    task automatic check_status(string tag);
        logic [31:0] r;
        reg_read(3'd1, r); check({tag, " R5 word count"}, r, m_words);
        reg_read(3'd0, r); check({tag, " R7 sync count"}, r, m_sync);
        reg_read(3'd2, r); check({tag, " R8 valid count"}, r, m_valid);
    endtask

    task automatic check_buffer(string tag);
        logic [DATA_W-1:0] r;
        for (int i = 0; i < m_words; i++) begin
            buf_read(i, r);
            check({tag, " R3 R4 R9 buffer word"}, r, m_mem[i]);
        end
    endtask

    initial begin
        logic [31:0] r;
        logic [DATA_W-1:0] b;
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        rst_n = 1;

        // R1 reset values, R9 version and unmapped reads
        reg_read(3'd0, r); check("R1 sync count", r, 0);
        reg_read(3'd1, r); check("R1 word count", r, 0);
        reg_read(3'd2, r); check("R1 valid count", r, 0);
        reg_read(3'd3, r); check("R1 skip", r, 0);
        reg_read(3'd7, r); check("R9 version", r, VER);
        for (int a = 4; a < 7; a++) begin
            reg_read(3'(a), r); check("R9 unmapped", r, 0);
        end

        // R2 syncs without arm start nothing
        for (int i = 0; i < 6; i++) beat(1, i == 2 || i == 4, 32'hA0 + i);
        check_status("R2 unarmed");

        // R3 skip 0: sync beat lands at address 0
        reg_write(3'd2, 0);
        beat(1, 0, 32'h1111);
        beat(1, 1, 32'hCAFE_0000);
        beat(0, 0, 32'hDEAD);
        beat(1, 0, 32'hCAFE_0001);
        check_status("R3 skip0");
        buf_read(0, b); check("R3 skip0 first word", b, 32'hCAFE_0000);
        buf_read(1, b); check("R4 second word", b, 32'hCAFE_0001);

        // R3 R4 skip 3 with idle beats in between
        reg_write(3'd3, 3);
        reg_read(3'd3, r); check("R3 skip readback", r, 3);
        reg_write(3'd2, 0);
        beat(1, 1, 32'h5000); beat(0, 0, 32'h5EEE); beat(1, 0, 32'h5001);
        beat(0, 1, 32'h5EEF); beat(1, 0, 32'h5002); beat(1, 0, 32'h5003);
        beat(0, 0, 32'h5EF0); beat(1, 0, 32'h5004);
        check_status("R3 skip3");
        buf_read(0, b); check("R3 skip3 first word", b, 32'h5003);
        check_buffer("R4 skip3");

        // R6 fill to full, then extra beats are ignored
        reg_write(3'd3, 1);
        reg_write(3'd2, 0);
        beat(1, 1, 32'h7000);
        for (int i = 0; i < DEPTH + 5; i++) beat(1, i == DEPTH + 2, 32'h7100 + i);
        reg_read(3'd1, r); check("R6 word count full", r, DEPTH);
        buf_read(0, b); check("R6 word 0 kept", b, 32'h7100);
        check_buffer("R6 full");
        reg_read(3'd0, r); check("R7 sync cleared by last read", r, 0);
        check_status("R6 after");

        // R10 re-arm aborts a partial fill
        reg_write(3'd3, 0);
        reg_write(3'd2, 0);
        beat(1, 1, 32'h9000); beat(1, 0, 32'h9001); beat(1, 0, 32'h9002);
        reg_write(3'd2, 0);
        for (int i = 0; i < 4; i++) beat(1, 0, 32'h9100 + i);
        reg_read(3'd1, r); check("R10 word count frozen", r, 3);
        buf_read(2, b); check("R10 word 2 untouched", b, 32'h9002);
        beat(1, 1, 32'h9200); beat(1, 0, 32'h9201);
        check_status("R10 restart");
        check_buffer("R10 restart");

        // R7 sync beat together with last-word read reads back as 1
        beat(1, 1, 32'h0);
        @(negedge clk);
        idle_inputs();
        in_valid = 1; in_sync = 1; in_data = 32'hBEEF;
        buf_rd = 1; buf_addr = ADDR_W'(DEPTH - 1);
        model_beat(1, 1, 32'hBEEF);
        m_sync = 1;
        reg_read(3'd0, r); check("R7 clear with sync", r, 1);
        check_status("R7 after");

        // Random captures
        for (int it = 0; it < 25; it++) begin
            int sk = $urandom_range(0, 5);
            reg_write(3'd3, 32'(sk));
            reg_write(3'd2, 0);
            for (int i = 0; i < 3 + $urandom_range(0, 4); i++)
                beat($urandom_range(0, 3) != 0, 0, $urandom);
            beat(1, 1, $urandom);
            for (int i = 0; i < $urandom_range(4, DEPTH + 8); i++)
                beat($urandom_range(0, 3) != 0, $urandom_range(0, 9) == 0, $urandom);
            check_status("random");
            check_buffer("random");
        end

        done = 1'b1;
        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule